// File: doc/BRIEF.md
# Dual-Port Indirect Register Arbiter

This block sits in front of a chip's internal configuration space. Two masters reach that space through one small bank of 8-bit interface registers: a parallel microprocessor port and a serial control port. The serial control port delivers requests that are already decoded into an index, a direction and a data byte. An access from either side reads or writes one interface byte, selected by a 3-bit index.

An internal register is not written directly. The target address is loaded first into a high address byte (mode/high-address byte) and a low address byte. Data bytes are then staged into the upper data bytes as needed. A write to the lowest data byte commits the assembled word, and a single write strobe goes onto the internal bus.

The serial side always wins the bus. A parallel access that collides with serial traffic is held off, and the hold-off is signalled by whichever of two handshake styles the system selects. The first style drops a ready line while the access is held. The second style delays an active-low acknowledge until the access has been done.

Top module: `dual_port_reg_arbiter`

## Requirements
- R1: After reset, all interface bytes read 0, p_rdy is 1, p_dtack_n is 1, s_ack is 0 and reg_we is 0.
- R2: When s_req and p_req are both high in a cycle, the serial access is performed in that cycle. The parallel access is performed in the first cycle in which s_req is low.
- R3: With hs_mode=0 (ready style), p_rdy is 0 while p_req is high, the parallel access is not yet done and s_req is high. p_rdy is 1 otherwise. p_dtack_n stays 1 in this style.
- R4: With hs_mode=1 (acknowledge style), p_dtack_n goes to 0 in the cycle after the parallel access is performed and stays 0 until p_req falls. p_rdy stays 1 in this style.
- R5: Index map: 0 to 4 select data bytes DR0 to DR4, 6 selects the low address byte and 7 selects the high address byte. Index 5 reads 0 and ignores writes.
- R6: A write to index 0 raises reg_we for exactly one cycle, in the cycle after the access. In that cycle reg_waddr is {index 7 byte, index 6 byte} and reg_wdata is {DR4, DR3, DR2, DR1, written byte}.
- R7: Writes to any index other than 0 leave reg_we at 0. The staged bytes are kept until they are overwritten.
- R8: A read returns the byte currently held at that index and changes no state. The data appears on p_rdata or s_rdata in the cycle after the access.
- R9: s_ack is high for one cycle, in the cycle after each serial access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | Parallel handshake style: 0 ready line, 1 acknowledge |
| s_req | input | 1 | Serial access request, one access per high cycle |
| s_wr | input | 1 | Serial access is a write |
| s_idx | input | 3 | Serial interface register index |
| s_wdata | input | 8 | Serial write byte |
| s_rdata | output | 8 | Serial read byte |
| s_ack | output | 1 | Serial access done pulse |
| p_req | input | 1 | Parallel request, held until handshake completes |
| p_wr | input | 1 | Parallel access is a write |
| p_idx | input | 3 | Parallel interface register index |
| p_wdata | input | 8 | Parallel write byte |
| p_rdata | output | 8 | Parallel read byte |
| p_rdy | output | 1 | Ready line (style 0), low while stalled |
| p_dtack_n | output | 1 | Active-low acknowledge (style 1) |
| reg_we | output | 1 | Internal register write strobe |
| reg_waddr | output | 16 | Internal register address |
| reg_wdata | output | 40 | Internal register write data |

## Verification
The bench drives the two ports at the same time in both handshake styles. A design that let the parallel side through first would return a stale byte or lose the serial write. The bench also holds the serial request for two cycles in a row, to catch an acknowledge that arrives too early. The commit word is checked after staged bytes come from a mix of both ports. This exposes byte-order swaps and a commit that fires on a write to a non-zero index. The bench writes to the unused index 5 and reads data bytes twice in a row. It expects no change and no strobe, so a design with a side effect on read or a write to a phantom register is caught.

// File: rtl/dpra_pkg.sv
package dpra_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_DR   = 5;
  localparam int IDX_W    = 3;
  localparam int IDX_LO   = 6;
  localparam int IDX_HI   = 7;
endpackage

// File: rtl/dpra_arbiter.sv
module dpra_arbiter #(
  parameter int IDX_W  = dpra_pkg::IDX_W,
  parameter int DATA_W = dpra_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_mode,
  input  logic              s_req,
  input  logic              s_wr,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              p_req,
  input  logic              p_wr,
  input  logic [IDX_W-1:0]  p_idx,
  input  logic [DATA_W-1:0] p_wdata,
  output logic              grant_s,
  output logic              grant_p,
  output logic              acc_valid,
  output logic              acc_we,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              p_done,
  output logic              p_rdy,
  output logic              p_dtack_n,
  output logic              s_ack
);
  logic p_done_d;
  logic s_ack_d;

  // serial side has absolute priority
  always_comb begin
    grant_s   = s_req;
    grant_p   = p_req & ~s_req & ~p_done;
    acc_valid = grant_s | grant_p;
    if (grant_s) begin
      acc_we    = s_wr;
      acc_idx   = s_idx;
      acc_wdata = s_wdata;
    end else begin
      acc_we    = grant_p & p_wr;
      acc_idx   = p_idx;
      acc_wdata = p_wdata;
    end
    p_done_d  = p_req & (p_done | grant_p);
    s_ack_d   = grant_s;
    p_rdy     = ~(~hs_mode & p_req & ~p_done & s_req);
    p_dtack_n = ~(hs_mode & p_req & p_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_done <= 1'b0;
      s_ack  <= 1'b0;
    end else begin
      p_done <= p_done_d;
      s_ack  <= s_ack_d;
    end
  end
endmodule

// File: rtl/dpra_ifregs.sv
module dpra_ifregs #(
  parameter int IDX_W  = dpra_pkg::IDX_W,
  parameter int DATA_W = dpra_pkg::DATA_W,
  parameter int NUM_DR = dpra_pkg::NUM_DR,
  parameter int IDX_LO = dpra_pkg::IDX_LO,
  parameter int IDX_HI = dpra_pkg::IDX_HI
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic                     acc_we,
  input  logic [IDX_W-1:0]         acc_idx,
  input  logic [DATA_W-1:0]        acc_wdata,
  input  logic                     grant_s,
  input  logic                     grant_p,
  output logic [DATA_W-1:0]        s_rdata,
  output logic [DATA_W-1:0]        p_rdata,
  output logic                     reg_we,
  output logic [2*DATA_W-1:0]      reg_waddr,
  output logic [NUM_DR*DATA_W-1:0] reg_wdata
);
  localparam logic [IDX_W-1:0] LO_SEL = IDX_W'(IDX_LO);
  localparam logic [IDX_W-1:0] HI_SEL = IDX_W'(IDX_HI);
  localparam logic [IDX_W-1:0] COMMIT_SEL = '0;

  logic [DATA_W-1:0] dr_q [NUM_DR];
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] rd_byte;
  logic              commit_d;
  logic [NUM_DR*DATA_W-1:0] word_d;
  logic              wr_hit_lo, wr_hit_hi;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DR; gi++) begin : g_dr
      logic hit;
      assign hit = acc_valid & acc_we & (acc_idx == IDX_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dr_q[gi] <= '0;
        else if (hit) dr_q[gi] <= acc_wdata;
      end
    end
  endgenerate

  always_comb begin
    wr_hit_lo = acc_valid & acc_we & (acc_idx == LO_SEL);
    wr_hit_hi = acc_valid & acc_we & (acc_idx == HI_SEL);
    rd_byte = '0;
    if (acc_idx == LO_SEL)      rd_byte = lo_q;
    else if (acc_idx == HI_SEL) rd_byte = hi_q;
    else begin
      for (int i = 0; i < NUM_DR; i++)
        if (acc_idx == IDX_W'(i)) rd_byte = dr_q[i];
    end
    commit_d = acc_valid & acc_we & (acc_idx == COMMIT_SEL);
    word_d = '0;
    word_d[DATA_W-1:0] = acc_wdata;
    for (int i = 1; i < NUM_DR; i++)
      word_d[i*DATA_W +: DATA_W] = dr_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      s_rdata   <= '0;
      p_rdata   <= '0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      if (wr_hit_lo) lo_q <= acc_wdata;
      if (wr_hit_hi) hi_q <= acc_wdata;
      if (grant_s)   s_rdata <= rd_byte;
      if (grant_p)   p_rdata <= rd_byte;
      reg_we <= commit_d;
      if (commit_d) begin
        reg_waddr <= {hi_q, lo_q};
        reg_wdata <= word_d;
      end
    end
  end
endmodule

// File: rtl/dual_port_reg_arbiter.sv
module dual_port_reg_arbiter #(
  parameter int IDX_W  = dpra_pkg::IDX_W,
  parameter int DATA_W = dpra_pkg::DATA_W,
  parameter int NUM_DR = dpra_pkg::NUM_DR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hs_mode,
  input  logic                     s_req,
  input  logic                     s_wr,
  input  logic [IDX_W-1:0]         s_idx,
  input  logic [DATA_W-1:0]        s_wdata,
  output logic [DATA_W-1:0]        s_rdata,
  output logic                     s_ack,
  input  logic                     p_req,
  input  logic                     p_wr,
  input  logic [IDX_W-1:0]         p_idx,
  input  logic [DATA_W-1:0]        p_wdata,
  output logic [DATA_W-1:0]        p_rdata,
  output logic                     p_rdy,
  output logic                     p_dtack_n,
  output logic                     reg_we,
  output logic [2*DATA_W-1:0]      reg_waddr,
  output logic [NUM_DR*DATA_W-1:0] reg_wdata
);
  logic              grant_s, grant_p, acc_valid, acc_we, p_done;
  logic [IDX_W-1:0]  acc_idx;
  logic [DATA_W-1:0] acc_wdata;

  dpra_arbiter #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode),
    .s_req(s_req), .s_wr(s_wr), .s_idx(s_idx), .s_wdata(s_wdata),
    .p_req(p_req), .p_wr(p_wr), .p_idx(p_idx), .p_wdata(p_wdata),
    .grant_s(grant_s), .grant_p(grant_p), .acc_valid(acc_valid),
    .acc_we(acc_we), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
    .p_done(p_done), .p_rdy(p_rdy), .p_dtack_n(p_dtack_n), .s_ack(s_ack)
  );

  dpra_ifregs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_DR(NUM_DR)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .grant_s(grant_s),
    .grant_p(grant_p), .s_rdata(s_rdata), .p_rdata(p_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
  );
endmodule

// File: rtl/dpra_checker.sv
module dpra_checker #(
  parameter int IDX_W = dpra_pkg::IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_mode,
  input logic             s_req,
  input logic             s_ack,
  input logic             p_req,
  input logic             p_rdy,
  input logic             p_dtack_n,
  input logic             p_done,
  input logic             grant_p,
  input logic             acc_valid,
  input logic             acc_we,
  input logic [IDX_W-1:0] acc_idx,
  input logic             reg_we
);
  assert_serial_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |-> !grant_p);
  assert_rdy_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_mode && p_req && !p_done && s_req) |-> !p_rdy);
  assert_rdy_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mode |-> p_rdy);
  assert_dtack_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode |-> p_dtack_n);
  assert_dtack_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode && grant_p && $past(hs_mode)) |=> (!p_dtack_n || !p_req));
  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(acc_valid && acc_we && acc_idx == '0));
  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |=> s_ack);
endmodule

bind dual_port_reg_arbiter dpra_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .s_req(s_req),
  .s_ack(s_ack), .p_req(p_req), .p_rdy(p_rdy), .p_dtack_n(p_dtack_n),
  .p_done(p_done), .grant_p(grant_p), .acc_valid(acc_valid),
  .acc_we(acc_we), .acc_idx(acc_idx), .reg_we(reg_we)
);

// File: tb/tb_dual_port_reg_arbiter.sv
`timescale 1ns/1ps
module tb_dual_port_reg_arbiter;
  localparam int CLK_NS = 10;
  localparam int NV = 14;
  // {serial, write, idx[2:0], data[7:0], expected read[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1,1'b1,3'd7,8'h03,8'h00},
    {1'b1,1'b1,3'd6,8'h45,8'h00},
    {1'b0,1'b1,3'd4,8'h11,8'h00},
    {1'b0,1'b1,3'd3,8'h22,8'h00},
    {1'b1,1'b1,3'd2,8'h33,8'h00},
    {1'b0,1'b1,3'd1,8'h44,8'h00},
    {1'b0,1'b0,3'd7,8'h00,8'h03},
    {1'b1,1'b0,3'd3,8'h00,8'h22},
    {1'b0,1'b1,3'd0,8'h55,8'h00},
    {1'b1,1'b0,3'd0,8'h00,8'h55},
    {1'b1,1'b1,3'd5,8'hAA,8'h00},
    {1'b0,1'b0,3'd5,8'h00,8'h00},
    {1'b1,1'b1,3'd0,8'h66,8'h00},
    {1'b0,1'b0,3'd6,8'h00,8'h45}
  };

  logic clk, rst_n, hs_mode;
  logic s_req, s_wr, p_req, p_wr;
  logic [2:0] s_idx, p_idx;
  logic [7:0] s_wdata, p_wdata, s_rdata, p_rdata;
  logic s_ack, p_rdy, p_dtack_n, reg_we;
  logic [15:0] reg_waddr;
  logic [39:0] reg_wdata;

  int n_chk, n_bad;
  bit done;
  logic [7:0] mreg [8];

  dual_port_reg_arbiter dut (.*);

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check_commit(input logic wr, input logic [2:0] idx, input logic [7:0] d);
    if (wr && idx == 3'd0) begin
      chk("R6 we", reg_we, 1'b1);
      chk("R6 addr", reg_waddr, {mreg[7], mreg[6]});
      chk("R6 data", reg_wdata, {mreg[4], mreg[3], mreg[2], mreg[1], d});
    end else begin
      chk("R7 no strobe", reg_we, 1'b0);
    end
  endtask

  task automatic ser_acc(input logic wr, input logic [2:0] idx, input logic [7:0] d,
                         input logic [7:0] exp, input bit chk_rd);
    s_req = 1; s_wr = wr; s_idx = idx; s_wdata = d;
    @(negedge clk);
    s_req = 0;
    chk("R9 ack", s_ack, 1'b1);
    if (chk_rd) chk("R8 serial read", s_rdata, exp);
    check_commit(wr, idx, d);
    if (wr && idx != 3'd5) mreg[idx] = d;
    @(negedge clk);
    chk("R9 ack single", s_ack, 1'b0);
  endtask

  task automatic par_acc(input logic wr, input logic [2:0] idx, input logic [7:0] d,
                         input logic [7:0] exp, input bit chk_rd);
    p_req = 1; p_wr = wr; p_idx = idx; p_wdata = d;
    @(negedge clk);
    chk("R4 dtack low", p_dtack_n, 1'b0);
    if (chk_rd) chk("R8 parallel read", p_rdata, exp);
    check_commit(wr, idx, d);
    if (wr && idx != 3'd5) mreg[idx] = d;
    p_req = 0;
    #1 chk("R4 dtack release", p_dtack_n, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS*100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    rst_n = 0; hs_mode = 1; s_req = 0; s_wr = 0; s_idx = 0; s_wdata = 0;
    p_req = 0; p_wr = 0; p_idx = 0; p_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdy", p_rdy, 1'b1);
    chk("R1 dtack", p_dtack_n, 1'b1);
    chk("R1 ack", s_ack, 1'b0);
    chk("R1 we", reg_we, 1'b0);
    rst_n = 1;
    @(negedge clk);
    ser_acc(0, 3'd7, 8'h00, 8'h00, 1);
    par_acc(0, 3'd0, 8'h00, 8'h00, 1);

    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = VEC[v];
      if (e[20]) ser_acc(e[19], e[18:16], e[15:8], e[7:0], !e[19]);
      else       par_acc(e[19], e[18:16], e[15:8], e[7:0], !e[19]);
    end
    chk("R7 idle", reg_we, 1'b0);

    // R5 unused index: write ignored, read twice without side effect
    par_acc(0, 3'd5, 8'h00, 8'h00, 1);
    ser_acc(0, 3'd0, 8'h00, 8'h66, 1);
    ser_acc(0, 3'd0, 8'h00, 8'h66, 1);

    // R2/R3 contention, ready style
    hs_mode = 0;
    @(negedge clk);
    p_req = 1; p_wr = 0; p_idx = 3'd4;
    s_req = 1; s_wr = 1; s_idx = 3'd4; s_wdata = 8'h77;
    #1 chk("R3 rdy low", p_rdy, 1'b0);
    chk("R3 dtack idle", p_dtack_n, 1'b1);
    @(negedge clk);
    chk("R2 serial first", s_ack, 1'b1);
    s_req = 0; mreg[4] = 8'h77;
    #1 chk("R3 rdy high", p_rdy, 1'b1);
    @(negedge clk);
    chk("R2 parallel after", p_rdata, 8'h77);
    chk("R3 dtack stays", p_dtack_n, 1'b1);
    p_req = 0;
    @(negedge clk);

    // R2/R4 contention, acknowledge style, serial held two cycles
    hs_mode = 1;
    @(negedge clk);
    p_req = 1; p_wr = 1; p_idx = 3'd1; p_wdata = 8'h99;
    s_req = 1; s_wr = 0; s_idx = 3'd1;
    #1 chk("R4 rdy high", p_rdy, 1'b1);
    @(negedge clk);
    chk("R2 serial reads old", s_rdata, 8'h44);
    chk("R4 dtack held", p_dtack_n, 1'b1);
    @(negedge clk);
    chk("R4 dtack still held", p_dtack_n, 1'b1);
    s_req = 0;
    @(negedge clk);
    chk("R4 dtack after", p_dtack_n, 1'b0);
    p_req = 0;
    @(negedge clk);
    ser_acc(0, 3'd1, 8'h00, 8'h99, 1);
    summary();
  end
endmodule